// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing strobes for a serial port from a fast module clock. A phase accumulator works as the first stage. On each enabled clock it adds a 9-bit fraction F. Each time the sum wraps past 512 it issues a divided-clock enable. The mean enable rate is therefore F/512 of the module clock. When the fractional mode is off, or F is zero, the enable fires on every enabled clock.

The divided enables decrement a 13-bit reload counter. Each time the counter is at zero it reloads the programmed value B, so its period is B+1 enables. Every reload produces a one-clock oversample strobe. A 4-bit counter of those strobes produces a bit strobe on every 16th one. The resulting bit rate is f_mod · (F/512) / (16 · (B+1)). For example, a 75 MHz clock with B = 0x17 and F = 0x12E gives about 115.2 kbit/s.

The configuration inputs (mode bit, fraction and reload value) are sampled only at a reload event. A new setting therefore never cuts a running period short. A low run enable freezes every stage without losing its state.

Top module: `fracBaudGen`

## Requirements
- R1: A synchronous reset clears the accumulator, the reload counter, the oversample counter and the latched configuration, and drives both strobes low. The latched mode after reset is the bypass mode. With run enabled from the first clock after reset, the first oversample strobe is high in the cycle after that clock.
- R2: In bypass mode (latched mode bit 0, or latched fraction 0), one divided enable occurs per enabled clock, so the oversample strobe recurs every B+1 clocks.
- R3: In fractional mode with latched fraction F (1..511), the accumulator adds F each enabled clock and emits an enable on each wrap past 512. Over any 512 enabled clocks with a constant setting, exactly F enables occur. Consecutive enables are either floor(512/F) or ceil(512/F) clocks apart.
- R4: The reload counter counts down by one per divided enable and reloads B when an enable finds it at zero. The oversample strobe is high for exactly the one cycle after each such reload.
- R5: The bit strobe is high only together with an oversample strobe, on every 16th oversample strobe counted from reset.
- R6: Changes to B, F or the mode bit take effect only at the next reload event. The period in progress completes with the old setting.
- R7: While run is low, no stage changes state and both strobes stay low. When run returns high, timing resumes from the held state.
- R8: The bit strobe is never high in two consecutive cycles.
- R9: With B = 0x17 and F = 0x12E, exactly 302 oversample strobes occur in 12288 clocks (115.2 kbit/s at 75 MHz). With B = 0xAE and F = 0x16F, exactly 367 occur in 89600 clocks (19.2 kbit/s at 75 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run enable; low freezes all stages |
| fracMode | input | 1 | Fractional divider enable, sampled at reload |
| fracVal | input | 9 | Fraction F in units of 1/512, sampled at reload |
| reloadVal | input | 13 | Reload value B, sampled at reload |
| ovsTick | output | 1 | One-cycle oversample strobe per reload |
| bitTick | output | 1 | Strobe on every 16th oversample strobe |

## Verification
The bench covers several corner cases. F = 0 with the mode bit set must behave as bypass; a design that treated it as a stopped divider would never tick. A configuration change in the middle of a period must let the old period finish; a design that loaded B at once would produce a short first interval. A frozen run must hold the accumulator phase; a design that cleared it would shift every later strobe against the reference model. The two rate examples count strobes exactly, so an off-by-one in the B+1 period or in the accumulator wrap shows up as a count mismatch.

// File: rtl/fracBaudPkg.sv
package fracBaudPkg;
  typedef struct packed {
    logic count;   // divided enable with counter non-zero: decrement
    logic reload;  // divided enable with counter at zero: reload and tick
  } baudStrobes_t;
endpackage

// File: rtl/fbgPhaseCtl.sv
module fbgPhaseCtl
  import fracBaudPkg::*;
#(
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fracModeIn,
  input  logic [FRAC_W-1:0] fracValIn,
  input  logic              cntZero,
  output baudStrobes_t      strobes
);
  localparam int HALF = 2 ** (FRAC_W - 1);

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W-1:0] curFrac;
  logic              curMode;
  logic [FRAC_W:0]   sum;
  logic              bypass;
  logic              divEn;

  always_comb begin
    bypass         = !curMode || (curFrac == '0);
    sum            = {1'b0, acc} + {1'b0, curFrac};
    divEn          = run && (bypass || sum[FRAC_W]);
    strobes.reload = divEn && cntZero;
    strobes.count  = divEn && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      curFrac <= '0;
      curMode <= 1'b0;
    end else begin
      if (run) acc <= bypass ? '0 : sum[FRAC_W-1:0];
      if (strobes.reload) begin
        curFrac <= fracValIn;
        curMode <= fracModeIn;
      end
    end
  end

  // R6
  cfgHold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.reload |=> ($stable(curFrac) && $stable(curMode)));
  // R7
  freezeAcc_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(acc));
  // R3
  accWrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bypass && divEn) |=> (acc < $past(acc)));
  // R3
  accRise_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bypass && !divEn) |=> (acc > $past(acc)));
  // R3
  slowSpacing_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && int'(curFrac) <= HALF && divEn && !strobes.reload) |=> !divEn);
endmodule

// File: rtl/fbgTickPath.sv
module fbgTickPath
  import fracBaudPkg::*;
#(
  parameter int BG_W = 13,
  parameter int OVS  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  baudStrobes_t    strobes,
  input  logic [BG_W-1:0] reloadVal,
  output logic            cntZero,
  output logic            ovsTick,
  output logic            bitTick
);
  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

  logic [BG_W-1:0]  cnt;
  logic [OVS_W-1:0] ovsCnt;
  logic             ovsWrap;

  assign cntZero = (cnt == '0);

  generate
    if (OVS > 1) begin : g_div
      assign ovsWrap = (ovsCnt == OVS_LAST);
    end else begin : g_nodiv
      assign ovsWrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ovsCnt  <= '0;
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      ovsTick <= strobes.reload;
      bitTick <= strobes.reload && ovsWrap;
      if (strobes.reload) begin
        cnt    <= reloadVal;
        ovsCnt <= ovsWrap ? '0 : ovsCnt + 1'b1;
      end else if (strobes.count) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R4
  countDown_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.count |=> (cnt == $past(cnt) - 1'b1));
  // R4
  tickCause_chk: assert property (@(posedge clk) disable iff (rst)
    ovsTick |-> $past(cntZero));
  // R5
  bitWithOvs_chk: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> ovsTick);
  // R8
  bitSingle_chk: assert property (@(posedge clk) disable iff (rst)
    bitTick |=> !bitTick);
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import fracBaudPkg::*;
#(
  parameter int FRAC_W = 9,
  parameter int BG_W   = 13,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fracMode,
  input  logic [FRAC_W-1:0] fracVal,
  input  logic [BG_W-1:0]   reloadVal,
  output logic              ovsTick,
  output logic              bitTick
);
  baudStrobes_t strobes;
  logic         cntZero;

  fbgPhaseCtl #(.FRAC_W(FRAC_W)) i_ctl (
    .clk(clk), .rst(rst), .run(run),
    .fracModeIn(fracMode), .fracValIn(fracVal),
    .cntZero(cntZero), .strobes(strobes)
  );

  fbgTickPath #(.BG_W(BG_W), .OVS(OVS)) i_path (
    .clk(clk), .rst(rst), .strobes(strobes), .reloadVal(reloadVal),
    .cntZero(cntZero), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  // R7
  frozenQuiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ovsTick);
endmodule

// File: tb/test_fracBaudGen.sv
module test_fracBaudGen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic fracMode = 1'b0;
  logic [8:0] fracVal = '0;
  logic [12:0] reloadVal = '0;
  logic ovsTick, bitTick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mAcc, mCnt, mOvs, mFrac;
  bit mMode, expOvs, expBit;

  // interval monitor for R3
  bit chkGap = 1'b0;
  int gapLo, gapHi, gapCnt, gapLast;
  bit gapArmed = 1'b0;
  bit prevBit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracBaudGen i_fracBaudGen (
    .clk(clk), .rst(rst), .run(run), .fracMode(fracMode),
    .fracVal(fracVal), .reloadVal(reloadVal),
    .ovsTick(ovsTick), .bitTick(bitTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: updated at every rising edge from the driven inputs
  always @(posedge clk) begin
    bit byp, de, rl;
    if (rst) begin
      mAcc = 0; mCnt = 0; mOvs = 0; mFrac = 0; mMode = 0;
      expOvs = 0; expBit = 0;
    end else if (!run) begin
      expOvs = 0; expBit = 0;
    end else begin
      byp = !mMode || (mFrac == 0);
      de = byp ? 1'b1 : ((mAcc + mFrac) >= 512);
      mAcc = byp ? 0 : (mAcc + mFrac) % 512;
      rl = de && (mCnt == 0);
      expOvs = rl;
      expBit = rl && (mOvs == 15);
      if (rl) begin
        mOvs = (mOvs + 1) % 16;
        mCnt = int'(reloadVal);
        mFrac = int'(fracVal);
        mMode = fracMode;
      end else if (de) begin
        mCnt = mCnt - 1;
      end
    end
  end

  // per-cycle comparison and interval monitor
  always @(negedge clk) begin
    if (!done) begin
      check(ovsTick === expOvs, "R4 ovsTick vs model", int'(ovsTick), int'(expOvs));
      check(bitTick === expBit, "R5 bitTick vs model", int'(bitTick), int'(expBit));
      check(!(prevBit && bitTick), "R8 bitTick back-to-back", int'(bitTick), 0);
      prevBit = bitTick;
      if (chkGap) begin
        gapCnt++;
        if (ovsTick) begin
          if (gapArmed)
            check(gapCnt >= gapLo && gapCnt <= gapHi, "R3 enable spacing", gapCnt, gapLo);
          gapArmed = 1'b1;
          gapCnt = 0;
          gapLast = gapCnt;
        end
      end else begin
        gapArmed = 1'b0;
        gapCnt = 0;
      end
    end
  end

  task automatic countTicks(input int n, output int o, output int b);
    o = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovsTick) o++;
      if (bitTick) b++;
    end
  endtask

  task automatic clocksToTick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ovsTick && n < 20000);
  endtask

  task automatic setCfg(input bit m, input int f, input int bg);
    fracMode = m;
    fracVal = 9'(f);
    reloadVal = 13'(bg);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int o, b, n;
    setCfg(0, 0, 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ovsTick == 0 && bitTick == 0, "R1 strobes low in reset", int'(ovsTick), 0);
    rst = 1'b0;
    run = 1'b1;
    @(negedge clk);
    check(ovsTick == 1, "R1 first tick after reset", int'(ovsTick), 1);

    // R2: bypass, period B+1 = 4
    countTicks(64, o, b);
    check(o == 16, "R2 bypass tick count", o, 16);
    countTicks(256, o, b);
    check(b == 4, "R5 bit ticks per 16 ovs", b, 4);

    // R2: fraction zero with mode on is still bypass
    setCfg(1, 0, 3);
    repeat (8) @(negedge clk);
    countTicks(64, o, b);
    check(o == 16, "R2 zero fraction bypass", o, 16);

    // R3: fractional F=100, B=0
    setCfg(1, 100, 0);
    repeat (12) @(negedge clk);
    gapLo = 5; gapHi = 6;
    chkGap = 1'b1;
    countTicks(512, o, b);
    chkGap = 1'b0;
    check(o == 100, "R3 enables per 512 clocks", o, 100);

    // R3: F=300 (spacing 1 or 2)
    setCfg(1, 300, 0);
    repeat (12) @(negedge clk);
    gapLo = 1; gapHi = 2;
    chkGap = 1'b1;
    countTicks(512, o, b);
    chkGap = 1'b0;
    check(o == 300, "R3 enables per 512 clocks F=300", o, 300);

    // R6: change B mid-period
    setCfg(0, 0, 50);
    clocksToTick(n);
    clocksToTick(n);
    repeat (10) @(negedge clk);
    setCfg(0, 0, 5);
    clocksToTick(n);
    check(n == 41, "R6 old period completes", n, 41);
    clocksToTick(n);
    check(n == 6, "R6 new period after reload", n, 6);

    // R7: freeze
    setCfg(1, 200, 7);
    repeat (40) @(negedge clk);
    run = 1'b0;
    countTicks(30, o, b);
    check(o == 0 && b == 0, "R7 no ticks while frozen", o, 0);
    run = 1'b1;
    countTicks(200, o, b);
    check(o > 0, "R7 ticks resume", o, 1);

    // R9: 115.2 kbit/s example
    setCfg(1, 'h12E, 'h17);
    repeat (200) @(negedge clk);
    countTicks(12288, o, b);
    check(o == 302, "R9 115.2k oversample count", o, 302);
    check(b >= 18 && b <= 19, "R9 115.2k bit count", b, 18);

    // R9: 19.2 kbit/s example
    setCfg(1, 'h16F, 'hAE);
    repeat (1000) @(negedge clk);
    countTicks(89600, o, b);
    check(o == 367, "R9 19.2k oversample count", o, 367);

    // R1: reset mid-run returns to bypass start
    rst = 1'b1;
    @(negedge clk);
    check(ovsTick == 0 && bitTick == 0, "R1 reset clears strobes", int'(ovsTick), 0);
    rst = 1'b0;
    setCfg(0, 0, 2);
    countTicks(9, o, b);
    check(o == 3, "R1 bypass after reset", o, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule